// File: doc/BRIEF.md
# Flash Command Front-End

This block puts a register interface in front of a small on-chip flash array and drives the array through a simple memory-mapped bus. Software first unlocks the control register with a fixed two-word key sequence. It then either programs the array, eight bytes at a time, by writing into the flash address window while programming mode is on, or erases a single page by choosing a bank and a page and setting a launch bit. The array is a behavioural memory. Programming takes a fixed number of cycles and erasing takes a longer fixed number.

While an operation runs, a per-bank busy flag stays high. Software polls it until it drops. Any rejected request leaves the array untouched and sets a sticky error flag in the status register. A request can be rejected because the target location is not blank, because the page is write-protected, or because the word pair is misaligned. Writing 1 to an error flag clears it. Reading the status register and writing the same value back therefore clears every error that is set.

Bus map: byte addresses below the array size (256 bytes by default) reach the array. Address 0x1000 is the key register, 0x1004 the control register and 0x1008 the status register. Reads return data combinationally in the same cycle.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset the control register reads 0x8000_0000 (lock flag, bit 31, set), the status register reads 0, and every array word reads 0xFFFF_FFFF.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register unlocks the control register, which then reads with bit 31 clear.
- R3: While the control register is locked, writes to it have no effect. A wrong key, or the right keys in the wrong order, keeps it locked until reset, even if the correct sequence follows.
- R4: Writing a control word with bit 31 set locks the register again, leaving its other fields unchanged. The two-key sequence then unlocks it once more.
- R5: With the program-enable bit (control bit 0) set, two 32-bit writes to consecutive words, the first 8-byte aligned, start a program. Status busy stays high for exactly PROG_CYCLES cycles, and afterwards both words read back the written data.
- R6: If the first word of a pair is not 8-byte aligned, or the second write is not to the next word, status bit 6 (alignment error) is set and the array is unchanged.
- R7: Programming a pair where either target word is not 0xFFFF_FFFF sets status bit 4 (program error) and leaves the array unchanged.
- R8: A control write with bit 1 (erase), bit 2 (bank), bits [5:4] (page in bank) and bit 16 (launch, reads 0) starts a page erase. Busy stays high for exactly ERASE_CYCLES cycles, then every word of that page reads 0xFFFF_FFFF and other pages are unchanged.
- R9: A program or erase aimed at a page whose wp_mask bit is set (global page = bank*PAGES_PER_BANK + page) sets status bit 5 (protection error), raises no busy flag and leaves the array unchanged.
- R10: Status bit 0 is the busy flag for operations on bank 0 and bit 1 is the busy flag for bank 1. Bank 1 holds the upper half of the array.
- R11: A status write clears each error flag whose bit is written as 1 and leaves flags written as 0 unchanged.
- R12: Array writes have no effect while program-enable is 0, and control writes are ignored while any operation is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data, little-endian word |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| wp_mask | input | 2*PAGES_PER_BANK | Per-page write-protect flags |

## Verification
The key sequencer is exercised with three key patterns: the correct pair, the pair in reverse order, and the correct pair after a wrong one. Together these separate a sequencer that tracks order and poisons itself from one that only matches values. Programming is tried with an aligned consecutive pair, a misaligned first word, a non-consecutive second word, a pair over already written data and a pair into a protected page. Each of these must produce a different outcome: data written, alignment error, program error or protection error. Erases aimed at each bank, including one at a protected page, show that busy is routed per bank, that the cycle counts are exact and that neighbouring pages are left intact.

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend #(
  parameter int PAGE_WORDS     = 8,
  parameter int PAGES_PER_BANK = 4,
  parameter int PROG_CYCLES    = 6,
  parameter int ERASE_CYCLES   = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_en,
  input  logic                        bus_we,
  input  logic [15:0]                 bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [2*PAGES_PER_BANK-1:0] wp_mask
);
  localparam int PAGES = 2 * PAGES_PER_BANK;
  localparam int WORDS = PAGES * PAGE_WORDS;
  localparam int WI_W  = $clog2(WORDS);
  localparam int PWW   = $clog2(PAGE_WORDS);
  localparam int PG_W  = $clog2(PAGES_PER_BANK);
  localparam int GP_W  = $clog2(PAGES);
  localparam int CW    = $clog2(ERASE_CYCLES + PROG_CYCLES + 1);
  localparam logic [15:0] FLASH_END = 16'(WORDS * 4);
  localparam logic [31:0] KEY_A = 32'h4567_0123;
  localparam logic [31:0] KEY_B = 32'hCDEF_89AB;
  localparam logic [31:0] ONES  = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {K_WAIT_A, K_WAIT_B, K_OPEN, K_DEAD} key_t;

  key_t              key_st;
  logic [31:0]       mem [WORDS];
  logic              ctl_prog, ctl_erase, ctl_bank;
  logic [PG_W-1:0]   ctl_page;
  logic              err_prog, err_prot, err_align;
  logic [1:0]        busy_q;
  logic [CW-1:0]     cnt;
  logic              op_prog;
  logic [WI_W-1:0]   op_wi;
  logic [31:0]       op_d0, op_d1;
  logic [GP_W-1:0]   op_page;
  logic              pend_v;
  logic [WI_W-1:0]   pend_wi;
  logic [31:0]       pend_d;

  wire unlocked = (key_st == K_OPEN);
  wire busy_any = |busy_q;
  wire reg_sel  = (bus_addr[15:4] == 12'h100);
  wire fl_sel   = (bus_addr < FLASH_END);
  wire wr       = bus_en & bus_we;
  wire key_wr   = wr & reg_sel & (bus_addr[3:2] == 2'd0);
  wire ctl_wr   = wr & reg_sel & (bus_addr[3:2] == 2'd1);
  wire st_wr    = wr & reg_sel & (bus_addr[3:2] == 2'd2);
  wire fl_wr    = wr & fl_sel;
  wire [WI_W-1:0] wi = bus_addr[WI_W+1:2];

  wire [GP_W-1:0] er_page   = {bus_wdata[2], bus_wdata[4 +: PG_W]};
  wire [GP_W-1:0] pend_page = pend_wi[WI_W-1:PWW];
  wire            pair_ok   = (bus_addr[2:0] == 3'b000 ? 1'b0 : 1'b1) & (wi == pend_wi + 1'b1)
                              & (bus_addr[1:0] == 2'b00);
  wire            pair_blank = (mem[pend_wi] == ONES) && (mem[wi] == ONES);

  logic [31:0] ctl_rd, st_rd;
  always_comb begin
    ctl_rd             = '0;
    ctl_rd[0]          = ctl_prog;
    ctl_rd[1]          = ctl_erase;
    ctl_rd[2]          = ctl_bank;
    ctl_rd[4 +: PG_W]  = ctl_page;
    ctl_rd[31]         = ~unlocked;
    st_rd              = '0;
    st_rd[1:0]         = busy_q;
    st_rd[4]           = err_prog;
    st_rd[5]           = err_prot;
    st_rd[6]           = err_align;
  end

  always_comb begin
    bus_rdata = '0;
    if (fl_sel)
      bus_rdata = mem[wi];
    else if (reg_sel)
      case (bus_addr[3:2])
        2'd1:    bus_rdata = ctl_rd;
        2'd2:    bus_rdata = st_rd;
        default: bus_rdata = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_st    <= K_WAIT_A;
      for (int i = 0; i < WORDS; i++) mem[i] <= ONES;
      ctl_prog  <= 1'b0;
      ctl_erase <= 1'b0;
      ctl_bank  <= 1'b0;
      ctl_page  <= '0;
      err_prog  <= 1'b0;
      err_prot  <= 1'b0;
      err_align <= 1'b0;
      busy_q    <= '0;
      cnt       <= '0;
      op_prog   <= 1'b0;
      op_wi     <= '0;
      op_d0     <= '0;
      op_d1     <= '0;
      op_page   <= '0;
      pend_v    <= 1'b0;
      pend_wi   <= '0;
      pend_d    <= '0;
    end else begin
      if (key_wr) begin
        case (key_st)
          K_WAIT_A: key_st <= (bus_wdata == KEY_A) ? K_WAIT_B : K_DEAD;
          K_WAIT_B: key_st <= (bus_wdata == KEY_B) ? K_OPEN : K_DEAD;
          default:  key_st <= key_st;
        endcase
      end

      if (ctl_wr && unlocked && !busy_any) begin
        if (bus_wdata[31]) begin
          key_st <= K_WAIT_A;
        end else begin
          ctl_prog  <= bus_wdata[0];
          ctl_erase <= bus_wdata[1];
          ctl_bank  <= bus_wdata[2];
          ctl_page  <= bus_wdata[4 +: PG_W];
          if (!bus_wdata[0]) pend_v <= 1'b0;
          if (bus_wdata[16] && bus_wdata[1]) begin
            if (wp_mask[er_page]) begin
              err_prot <= 1'b1;
            end else begin
              op_prog         <= 1'b0;
              op_page         <= er_page;
              cnt             <= CW'(ERASE_CYCLES);
              busy_q[bus_wdata[2]] <= 1'b1;
            end
          end
        end
      end

      if (st_wr) begin
        if (bus_wdata[4]) err_prog  <= 1'b0;
        if (bus_wdata[5]) err_prot  <= 1'b0;
        if (bus_wdata[6]) err_align <= 1'b0;
      end

      if (fl_wr && ctl_prog && !busy_any) begin
        if (!pend_v) begin
          if (bus_addr[2:0] != 3'b000) begin
            err_align <= 1'b1;
          end else begin
            pend_v  <= 1'b1;
            pend_wi <= wi;
            pend_d  <= bus_wdata;
          end
        end else begin
          pend_v <= 1'b0;
          if (!pair_ok) begin
            err_align <= 1'b1;
          end else if (wp_mask[pend_page]) begin
            err_prot <= 1'b1;
          end else if (!pair_blank) begin
            err_prog <= 1'b1;
          end else begin
            op_prog   <= 1'b1;
            op_wi     <= pend_wi;
            op_d0     <= pend_d;
            op_d1     <= bus_wdata;
            cnt       <= CW'(PROG_CYCLES);
            busy_q[pend_wi[WI_W-1]] <= 1'b1;
          end
        end
      end

      if (busy_any) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy_q <= '0;
          if (op_prog) begin
            mem[op_wi]        <= op_d0;
            mem[op_wi + 1'b1] <= op_d1;
          end else begin
            for (int k = 0; k < PAGE_WORDS; k++)
              mem[{op_page, PWW'(k)}] <= ONES;
          end
        end
      end
    end
  end

  AST_OPEN_AFTER_KEY_B: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && bus_wdata == KEY_B && key_st == K_WAIT_B)); // R2
  AST_LOCKED_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable({ctl_prog, ctl_erase, ctl_bank, ctl_page})); // R3
  AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    key_st == K_DEAD |=> key_st == K_DEAD); // R3
  AST_BUSY_ENDS_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_any) |-> $past(cnt) == CW'(1)); // R5
  AST_PROT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_prot) |-> !busy_any); // R9
  AST_ONE_BANK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q[0] && busy_q[1])); // R10
  AST_W1C_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && bus_wdata[4]) |=> !err_prog); // R11
  AST_CTL_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_any |=> $stable({ctl_prog, ctl_erase, ctl_bank, ctl_page})); // R12
endmodule

// File: tb/flash_cmd_frontend_tb.sv
module flash_cmd_frontend_tb;
  localparam int PROG_CYC  = 6;
  localparam int ERASE_CYC = 20;
  localparam logic [15:0] A_KEY = 16'h1000, A_CTL = 16'h1004, A_ST = 16'h1008;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  wp_mask = 8'b0000_0100;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  flash_cmd_frontend #(.PAGE_WORDS(8), .PAGES_PER_BANK(4), .PROG_CYCLES(PROG_CYC),
    .ERASE_CYCLES(ERASE_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_mask(wp_mask));

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(A_KEY, 32'h4567_0123);
    wr(A_KEY, 32'hCDEF_89AB);
  endtask

  task automatic clear_st();
    logic [31:0] s;
    rd(A_ST, s);
    wr(A_ST, s);
  endtask

  task automatic count_busy(input int bit_i, output int n);
    logic [31:0] s;
    n = 0;
    rd(A_ST, s);
    while (s[bit_i] && n < 1000) begin
      n++;
      @(negedge clk);
      rd(A_ST, s);
    end
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    rd(A_CTL, v);  chk("R1 ctrl after reset", v, 32'h8000_0000);
    rd(A_ST, v);   chk("R1 status after reset", v, 32'h0);
    rd(16'h0000, v); chk("R1 array word 0 blank", v, 32'hFFFF_FFFF);
    rd(16'h00FC, v); chk("R1 array last word blank", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_lock_rules();
    logic [31:0] v;
    wr(A_CTL, 32'h1);
    rd(A_CTL, v); chk("R3 ctrl write while locked", v, 32'h8000_0000);
    wr(A_KEY, 32'hCDEF_89AB);
    wr(A_KEY, 32'h4567_0123);
    rd(A_CTL, v); chk("R3 reversed keys stay locked", v, 32'h8000_0000);
    unlock();
    rd(A_CTL, v); chk("R3 good keys after bad stay locked", v, 32'h8000_0000);
    do_reset();
    unlock();
    rd(A_CTL, v); chk("R2 unlocked after key pair", v, 32'h0);
  endtask

  task automatic t_program();
    logic [31:0] v, s;
    int n;
    wr(A_CTL, 32'h1);
    wr(16'h0000, 32'h1111_2222);
    wr(16'h0004, 32'h3333_4444);
    rd(A_ST, s); chk("R10 bank0 busy bits", s & 32'h3, 32'h1);
    count_busy(0, n);
    chk("R5 program busy cycles", n, PROG_CYC);
    rd(16'h0000, v); chk("R5 first word", v, 32'h1111_2222);
    rd(16'h0004, v); chk("R5 second word", v, 32'h3333_4444);
    wr(16'h0000, 32'h0);
    wr(16'h0004, 32'h0);
    rd(A_ST, s); chk("R7 program error flag", s, 32'h10);
    rd(16'h0000, v); chk("R7 word unchanged", v, 32'h1111_2222);
    wr(A_ST, 32'h0);
    rd(A_ST, s); chk("R11 zero write keeps flag", s, 32'h10);
    clear_st();
    rd(A_ST, s); chk("R11 write-back clears", s, 32'h0);
  endtask

  task automatic t_align();
    logic [31:0] v, s;
    wr(16'h0014, 32'hAAAA_0001);
    rd(A_ST, s); chk("R6 misaligned first word", s, 32'h40);
    rd(16'h0014, v); chk("R6 misaligned word untouched", v, 32'hFFFF_FFFF);
    clear_st();
    wr(16'h0020, 32'hBBBB_0001);
    wr(16'h0028, 32'hBBBB_0002);
    rd(A_ST, s); chk("R6 non-consecutive pair", s, 32'h40);
    rd(16'h0020, v); chk("R6 first of bad pair untouched", v, 32'hFFFF_FFFF);
    clear_st();
  endtask

  task automatic t_bank1_and_prot();
    logic [31:0] v, s;
    int n;
    wr(16'h0080, 32'hC0DE_0080);
    wr(16'h0084, 32'hC0DE_0084);
    rd(A_ST, s); chk("R10 bank1 busy bits", s & 32'h3, 32'h2);
    count_busy(1, n);
    chk("R5 bank1 program cycles", n, PROG_CYC);
    rd(16'h0084, v); chk("R5 bank1 readback", v, 32'hC0DE_0084);
    wr(16'h0040, 32'h5);
    wr(16'h0044, 32'h6);
    rd(A_ST, s); chk("R9 program protected page", s, 32'h20);
    rd(16'h0040, v); chk("R9 protected word unchanged", v, 32'hFFFF_FFFF);
    clear_st();
    wr(A_CTL, 32'h0);
    wr(16'h0030, 32'h7);
    wr(16'h0034, 32'h8);
    rd(16'h0030, v); chk("R12 write with program off", v, 32'hFFFF_FFFF);
    rd(A_ST, s); chk("R12 no busy/error with program off", s, 32'h0);
  endtask

  task automatic t_erase();
    logic [31:0] v, s;
    int n;
    wr(A_CTL, 32'h0001_0002);
    rd(A_ST, s); chk("R10 erase bank0 busy", s & 32'h3, 32'h1);
    count_busy(0, n);
    chk("R8 erase busy cycles", n, ERASE_CYC);
    rd(16'h0000, v); chk("R8 erased word 0", v, 32'hFFFF_FFFF);
    rd(16'h0004, v); chk("R8 erased word 1", v, 32'hFFFF_FFFF);
    rd(16'h0080, v); chk("R8 other page intact", v, 32'hC0DE_0080);
    rd(A_CTL, v); chk("R8 launch bit reads 0", v, 32'h2);
    wr(A_CTL, 32'h0001_0022);
    rd(A_ST, s); chk("R9 erase protected page", s, 32'h20);
    clear_st();
    wr(A_CTL, 32'h0001_0006);
    wr(A_CTL, 32'h0000_0001);
    rd(A_CTL, v); chk("R12 ctrl write during busy", v, 32'h6);
    rd(A_ST, s); chk("R10 erase bank1 busy", s & 32'h3, 32'h2);
    count_busy(1, n);
    rd(16'h0080, v); chk("R8 bank1 page erased", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_relock();
    logic [31:0] v;
    wr(A_CTL, 32'h0);
    wr(A_CTL, 32'h8000_0000);
    rd(A_CTL, v); chk("R4 relocked", v, 32'h8000_0000);
    wr(A_CTL, 32'h1);
    rd(A_CTL, v); chk("R4 write after relock ignored", v, 32'h8000_0000);
    unlock();
    rd(A_CTL, v); chk("R4 unlock again", v, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_lock_rules();
    t_program();
    t_align();
    t_bank1_and_prot();
    t_erase();
    t_relock();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule